// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit countdown timer clocked from the system clock through a power-of-two prescaler. A small write port sets three registers: the start value of the count, a divide setting that picks the prescaler ratio, and a timer entry that holds an 8-bit vector, a mask bit and a mode bit. Loading the start value restarts both the count and the prescaler. The count and the current register values are visible on output ports at all times.

In single-shot mode the count steps down once per prescaled tick, stays at zero, and raises one event on the tick after it reached zero. In repeating mode the count goes from the start value down through zero and reloads, so one event is raised every start-value-plus-one ticks. Each event is a one-cycle pulse with the vector from the timer entry, meant for an interrupt controller. A start value of zero never raises an event.

Top module: `divtimer`

## Requirements
- R1: After reset `cur_count` is 0, `div_cfg` is 0, `timer_entry` is 0x10000 (masked, single-shot, vector 0) and `evt_valid` is low.
- R2: A write with `wr_sel`=1 stores `wr_data[3:0]` AND 0xB into `div_cfg`; bit 2 always reads 0. `wr_sel`=3 writes nothing.
- R3: The prescaler shift is (code + 1) mod 8, where code = {div_cfg[3], div_cfg[1:0]}; one tick occurs every 2^shift clocks, so div_cfg=0 divides by 2 and div_cfg=0xB divides by 1.
- R4: In single-shot mode (`timer_entry[17]`=0) the count k clocks after a load is max(0, start − floor(k / 2^shift)).
- R5: In single-shot mode exactly one event is raised, on the tick that follows the count reaching zero (tick number start+1); the count then stays at 0 with no further events.
- R6: In repeating mode (`timer_entry[17]`=1) the count after T ticks is start − (T mod (start+1)) and an event is raised on every tick where T is a nonzero multiple of start+1.
- R7: With a start value of 0 the count stays 0 and no event is raised in either mode.
- R8: While `timer_entry[16]` is set no event is raised, but counting continues; a write to the timer entry (`wr_sel`=2, bits [17:0]) takes effect for events from the second clock after it.
- R9: A write with `wr_sel`=0 loads `wr_data` into the count on the next clock, restarts the prescaler, suppresses any event on that clock and rearms a finished single-shot run.
- R10: An event is a single-cycle high on `evt_valid` with `evt_vector` equal to `timer_entry[7:0]` in force at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start value, 1 divide, 2 timer entry, 3 none |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Present count |
| div_cfg | output | 4 | Stored divide setting |
| timer_entry | output | 18 | Stored timer entry: [17] repeat, [16] mask, [7:0] vector |
| evt_valid | output | 1 | Timer event pulse |
| evt_vector | output | 8 | Vector carried with the event |

## Verification
The bench builds the block with its default 32-bit count, so a start value near the top of the range can be loaded while small start values reach expiry quickly. It sweeps every divide code, from divide-by-1 through divide-by-128, over short random start values in both modes, which puts single-shot expiry, repeating reload and mid-run mask changes within a few thousand clocks. The reference count and event timing are computed per clock from the elapsed clock count since the last load.

// File: rtl/divtimer.sv
module divtimer #(
  parameter int CW = 32,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cur_count,
  output logic [3:0]    div_cfg,
  output logic [17:0]   timer_entry,
  output logic          evt_valid,
  output logic [VW-1:0] evt_vector
);
  localparam int PSW = 7;
  localparam logic [17:0] ENTRY_RST = 18'h10000;

  logic [CW-1:0]  init_q, cnt_q;
  logic [3:0]     div_q;
  logic [17:0]    ent_q;
  logic [PSW-1:0] psc_q;
  logic           done_q;

  wire [2:0]     code    = {div_q[3], div_q[1:0]};
  wire [2:0]     shift   = code + 3'd1;
  wire [PSW-1:0] lowmask = PSW'((8'd1 << shift) - 8'd1);
  wire           tick    = (psc_q & lowmask) == lowmask;
  wire           repeat_m = ent_q[17];
  wire           masked  = ent_q[16];
  wire           load    = wr_en && (wr_sel == 2'd0);
  wire           expire  = tick && (cnt_q == '0) && (init_q != '0) && (repeat_m || !done_q);

  assign cur_count   = cnt_q;
  assign div_cfg     = div_q;
  assign timer_entry = ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= '0;
      cnt_q      <= '0;
      div_q      <= '0;
      ent_q      <= ENTRY_RST;
      psc_q      <= '0;
      done_q     <= 1'b0;
      evt_valid  <= 1'b0;
      evt_vector <= '0;
    end else begin
      evt_valid  <= expire && !masked && !load;
      evt_vector <= ent_q[VW-1:0];
      if (load) begin
        init_q <= wr_data;
        cnt_q  <= wr_data;
        psc_q  <= '0;
        done_q <= 1'b0;
      end else begin
        psc_q <= psc_q + 1'b1;
        if (tick) begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (expire) begin
            if (repeat_m) cnt_q <= init_q;
            else done_q <= 1'b1;
          end
        end
      end
      if (wr_en && wr_sel == 2'd1) div_q <= wr_data[3:0] & 4'hB;
      if (wr_en && wr_sel == 2'd2) ent_q <= wr_data[17:0];
    end
  end
endmodule

module divtimer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [CW-1:0] wr_data,
  input logic [CW-1:0] cur_count,
  input logic [3:0]    div_cfg,
  input logic [17:0]   timer_entry,
  input logic          evt_valid,
  input logic [CW-1:0] init_q
);
  assert_div_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> div_cfg == ($past(wr_data[3:0]) & 4'hB));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel == 2'd0) && cur_count != '0) |=>
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1));

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel == 2'd0) && !timer_entry[17] && cur_count == '0) |=> cur_count == '0);

  assert_zero_start_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0) |=> !evt_valid);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_entry[16] |=> !evt_valid);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (cur_count == $past(wr_data) && !evt_valid));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
endmodule

bind divtimer divtimer_chk #(.CW(CW)) u_chk (.*);

// File: tb/divtimer_bench.sv
module divtimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic [3:0]  div_cfg;
  logic [17:0] timer_entry;
  logic        evt_valid;
  logic [7:0]  evt_vector;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  divtimer u_divtimer (.*);

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 190000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected under 190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int shift_of(logic [3:0] d);
    return (int'({d[3], d[1:0]}) + 1) % 8;
  endfunction

  function automatic void model(longint start, int sh, bit per, int k,
                                output longint cnt, output bit ev);
    longint t = longint'(k) >> sh;
    bit tk = (k > 0) && ((k & ((1 << sh) - 1)) == 0);
    if (start == 0) begin
      cnt = 0; ev = 1'b0;
    end else if (per) begin
      cnt = start - (t % (start + 1));
      ev = tk && (t % (start + 1) == 0);
    end else begin
      cnt = (t >= start) ? 0 : start - t;
      ev = tk && (t == start + 1);
    end
  endfunction

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  logic [17:0] ent_model;
  logic [3:0]  div_model;

  task automatic run(string tag, logic [31:0] start, int ncyc, int flip_at);
    longint ec; bit ev; logic [17:0] ent_before;
    int sh = shift_of(div_model);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = start;
    for (int k = 0; k <= ncyc; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      ent_before = ent_model;
      if (k > 0 && k - 1 == flip_at) ent_model = ent_model ^ 18'h10000;
      if (k == flip_at) begin
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = {14'd0, ent_model ^ 18'h10000};
      end
      model(longint'(start), sh, ent_before[17], k, ec, ev);
      check({tag, " count R4/R6"}, longint'(cur_count), ec);
      check({tag, " event R5/R6/R8"}, longint'(evt_valid), longint'(ev && !ent_before[16]));
      if (evt_valid) check({tag, " vector R10"}, longint'(evt_vector), longint'(ent_before[7:0]));
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(logic [3:0] d);
    wr(2'd1, {28'd0, d});
    div_model = d & 4'hB;
  endtask

  task automatic set_ent(logic [17:0] e);
    wr(2'd2, {14'd0, e});
    ent_model = e;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 count", longint'(cur_count), 0);
    check("R1 div", longint'(div_cfg), 0);
    check("R1 entry", longint'(timer_entry), 18'h10000);
    check("R1 event", longint'(evt_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after release", longint'(cur_count), 0);
    ent_model = 18'h10000; div_model = 4'h0;

    wr(2'd1, 32'hFFFF_FFFF);
    check("R2 mask 0xB", longint'(div_cfg), 4'hB);
    wr(2'd3, 32'h0003_0004);
    check("R2 sel3 ignored div", longint'(div_cfg), 4'hB);
    check("R2 sel3 ignored entry", longint'(timer_entry), 18'h10000);
    div_model = 4'hB;

    set_ent(18'h2005A);
    check("R8 entry store", longint'(timer_entry), 18'h2005A);
    run("R3 div1 periodic", 32'd3, 20, -1);

    set_div(4'h0);
    set_ent(18'h00033);
    run("R5 oneshot div2", 32'd5, 30, -1);
    run("R9 restart oneshot", 32'd2, 20, -1);

    set_ent(18'h20077);
    run("R7 zero periodic", 32'd0, 40, -1);
    set_ent(18'h00077);
    run("R7 zero oneshot", 32'd0, 40, -1);

    set_div(4'h8);
    set_ent(18'h30011);
    run("R8 masked then unmasked", 32'd2, 200, 50);

    set_div(4'hB);
    set_ent(18'h00001);
    run("R4 large start", 32'hFFFF_FFF0, 40, -1);

    for (int i = 0; i < 30; i++) begin
      logic [3:0] d = 4'($urandom);
      logic [31:0] st = $urandom % 12;
      logic [17:0] e = {1'($urandom), ($urandom % 4 == 0), 8'd0, 8'($urandom)};
      int span;
      set_div(d);
      set_ent(e);
      span = (int'(st) + 1) * (1 << shift_of(d)) * 2 + 5;
      if (span > 3000) span = 3000;
      run("random", st, span, ($urandom % 3 == 0) ? int'($urandom % span) : -1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule